// File: doc/BRIEF.md
# Device Power-State Sequencing Controller

This block tracks which power state a bus-attached device is in and moves it between states. The states are full operation (D0), an operating-but-uninitialised D0, three light sleep levels (D1, D2, D3hot), a deep sleep in which only the core supply stays up (D3warm), and full power removal (D3cold). Software asks for a new state by writing a two-bit request field and a power-off qualifier. Wake sources are latched as event bits, gated by per-source mask bits, and produce a single qualified wake.

The device's role decides what a wake does. As a host, a qualified wake brings the device straight back. As an agent, the wake only raises a power-management event line to the remote host. The device then stays asleep until the host writes state 00, which also resets the stored request field to 00. Going into and out of D3warm, and into D3cold, the block drives enables for the main and core supplies and waits for each supply's power-good input. A programmable timeout flags a supply that is slow to respond. Leaving D3warm always lands in the uninitialised D0, and software then signals that initialisation is complete.

Top module: `pwr_state_seq`

## Requirements
- R1: After reset, `state_o` is 0 (D0), both supply enables are 1, and `pme`, `busy`, `next_o` and `tmo_err` are 0.
- R2: `state_o` codes are D0=0, D0-uninit=1, D1=2, D2=3, D3hot=4, D3warm=5, D3cold=6. A request written in D0 with field 01, 10 or 11 (power-off 0) shows D1, D2 or D3hot on the cycle after the write edge. A request of 00 returns a light sleep state to D0.
- R3: Event bit i sets when `evt_set[i]` is 1 at a clock edge. It clears when `evt_clr_we` is 1 with `evt_clr[i]`=1, and a clear wins over a set. A wake qualifies only if some event bit and the same mask bit are both 1. Bit order: 0 USB, 1 Ethernet MAC, 2 GPIO, 3 PCI, 4 interrupt, 5 timer. A cleared event does not wake again.
- R4: In host role (`pme_en`=0), a qualified wake in D1, D2 or D3hot returns to D0 one edge later, and `pme` stays 0.
- R5: In agent role (`pme_en`=1), a qualified wake in any sleep state sets `pme` and leaves the state unchanged. A host write of 00 clears `pme`, leaves the sleep state, and forces `next_o` to 00.
- R6: `tmr_wake` or `irq_wake` takes D1, D2 or D3hot to D0 in either role.
- R7: A request of 11 with power-off 1 drops `main_en` while `core_en` stays 1. `busy` is 1 and `state_o` reads 0 until `main_pg` is low. Then the state is D3warm.
- R8: Leaving D3warm raises `main_en` first and holds `busy` until `main_pg` is high. The state then becomes D0-uninit (1) and stays there until `init_done`, which gives D0.
- R9: `cold_req` in D0 turns off the main supply and then, once `main_pg` is low, the core supply. When `core_pg` is low the state is D3cold (6), both enables stay 0, and only reset leaves it.
- R10: While `busy` is 1, requests and host writes change neither the state nor `next_o`.
- R11: `tmo_err` sets once a waited-for power-good has stayed off target for `tmo_limit` cycles. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_we | input | 1 | Software request write strobe |
| req_next | input | 2 | Requested state field |
| req_poff | input | 1 | Power-off qualifier for deep sleep |
| cold_req | input | 1 | Request full power removal |
| host_ps_we | input | 1 | Remote host power-state write strobe |
| host_ps_val | input | 2 | Value written by remote host |
| pme_en | input | 1 | 1 = agent role, 0 = host role |
| init_done | input | 1 | Software initialisation complete |
| tmr_wake | input | 1 | Timer wake request |
| irq_wake | input | 1 | Interrupt wake request |
| evt_set | input | 6 | Raw wake event pulses |
| evt_clr_we | input | 1 | Event clear strobe |
| evt_clr | input | 6 | Write-one-to-clear event bits |
| wake_mask | input | 6 | Per-source wake mask |
| main_pg | input | 1 | Main supply power-good |
| core_pg | input | 1 | Core supply power-good |
| tmo_limit | input | 16 | Power-good timeout in cycles |
| main_en | output | 1 | Main supply enable |
| core_en | output | 1 | Core supply enable |
| pme | output | 1 | Power-management event to host |
| state_o | output | 3 | Current state code |
| next_o | output | 2 | Stored request field |
| busy | output | 1 | Supply sequence in progress |
| evt_o | output | 6 | Latched event bits |
| tmo_err | output | 1 | Power-good timeout flag |

## Verification
The bench sets an event whose mask bit is 0 and checks that the device stays asleep. A design that qualified events without the mask would wake here. It then clears the event and sleeps again, which catches a stale bit that wakes the device a second time. In agent role it checks that the state holds while `pme` is up, and that a host write of 00 both wakes the device and zeroes the stored request. It also issues a request during a supply sequence and checks that it is dropped, and checks that leaving D3warm stops in the uninitialised D0 instead of going straight to D0. Once D3cold is reached it sends requests, host writes and wakes, and checks that none of them moves the state.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int NSRC     = 6;
  localparam int NSUP     = 2;
  localparam int SUP_MAIN = 0;
  localparam int SUP_CORE = 1;

  typedef enum logic [3:0] {
    ST_D0, ST_D0NI, ST_D1, ST_D2, ST_D3H, ST_D3W, ST_D3C,
    ST_DN, ST_UP, ST_CM, ST_CC
  } pstate_e;

  localparam logic [2:0] CODE_D0   = 3'd0;
  localparam logic [2:0] CODE_D0NI = 3'd1;
  localparam logic [2:0] CODE_D1   = 3'd2;
  localparam logic [2:0] CODE_D2   = 3'd3;
  localparam logic [2:0] CODE_D3H  = 3'd4;
  localparam logic [2:0] CODE_D3W  = 3'd5;
  localparam logic [2:0] CODE_D3C  = 3'd6;
endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] evt_o,
  output logic         wake_o
);
  logic [N-1:0] evt_q, evt_d, clr_vec;
  logic         evt_en;

  assign clr_vec = clr_we_i ? clr_i : '0;
  assign evt_en  = (|set_i) | clr_we_i;

  always_comb begin
    evt_d = (evt_q | set_i) & ~clr_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= '0;
    else if (evt_en) evt_q <= evt_d;
  end

  assign evt_o  = evt_q;
  assign wake_o = |(evt_q & mask_i);
endmodule

// File: rtl/pwr_pg_wait.sv
module pwr_pg_wait #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wait_i,
  input  logic          tgt_i,
  input  logic          pg_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o,
  output logic          tmo_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en, tmo_q, tmo_set, pending;

  assign done_o  = (pg_i == tgt_i);
  assign pending = wait_i & ~done_o;
  assign tmo_set = pending & (cnt_q == limit_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!pending)             cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end
  assign cnt_en = pending | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmo_q <= 1'b0;
    else if (tmo_set) tmo_q <= 1'b1;
  end

  assign tmo_o = tmo_q;
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_we,
  input  logic [1:0]      req_next,
  input  logic            req_poff,
  input  logic            cold_req,
  input  logic            host_wr00,
  input  logic            pme_en,
  input  logic            init_done,
  input  logic            tmr_wake,
  input  logic            irq_wake,
  input  logic            wake_q,
  input  logic [NSUP-1:0] pg_done,
  output logic [NSUP-1:0] sup_en,
  output logic [NSUP-1:0] sup_wait,
  output logic            pme_o,
  output logic [1:0]      next_o,
  output logic [2:0]      state_o,
  output logic            busy_o
);
  pstate_e    st_q, st_d;
  logic       pme_q, pme_d;
  logic [1:0] nxt_q, nxt_d;
  logic       busy, lowp, light, exit_req;

  assign busy  = (st_q == ST_DN) | (st_q == ST_UP) | (st_q == ST_CM) | (st_q == ST_CC);
  assign light = (st_q == ST_D1) | (st_q == ST_D2) | (st_q == ST_D3H);
  assign lowp  = light | (st_q == ST_D3W);
  assign exit_req = host_wr00 | (req_we & (req_next == 2'b00));

  always_comb begin
    st_d  = st_q;
    pme_d = pme_q;
    nxt_d = nxt_q;
    if (!busy) begin
      if (req_we)    nxt_d = req_next;
      if (host_wr00) nxt_d = 2'b00;
    end
    if (lowp && pme_en && wake_q) pme_d = 1'b1;
    if (!busy && host_wr00)       pme_d = 1'b0;
    case (st_q)
      ST_D0: begin
        if (cold_req) st_d = ST_CM;
        else if (req_we) begin
          case (req_next)
            2'b01:   st_d = ST_D1;
            2'b10:   st_d = ST_D2;
            2'b11:   st_d = req_poff ? ST_DN : ST_D3H;
            default: st_d = ST_D0;
          endcase
        end
      end
      ST_D1, ST_D2, ST_D3H: begin
        if (tmr_wake || irq_wake || (wake_q && !pme_en) || exit_req) st_d = ST_D0;
      end
      ST_D3W:  if ((wake_q && !pme_en) || host_wr00) st_d = ST_UP;
      ST_DN:   if (pg_done[SUP_MAIN]) st_d = ST_D3W;
      ST_UP:   if (pg_done[SUP_MAIN]) st_d = ST_D0NI;
      ST_CM:   if (pg_done[SUP_MAIN]) st_d = ST_CC;
      ST_CC:   if (pg_done[SUP_CORE]) st_d = ST_D3C;
      ST_D0NI: if (init_done) st_d = ST_D0;
      ST_D3C:  st_d = ST_D3C;
      default: st_d = ST_D0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_D0;
      pme_q <= 1'b0;
      nxt_q <= 2'b00;
    end else begin
      st_q  <= st_d;
      pme_q <= pme_d;
      nxt_q <= nxt_d;
    end
  end

  always_comb begin
    sup_en[SUP_MAIN] = !((st_q == ST_DN) || (st_q == ST_D3W) || (st_q == ST_CM) ||
                         (st_q == ST_CC) || (st_q == ST_D3C));
    sup_en[SUP_CORE] = !((st_q == ST_CC) || (st_q == ST_D3C));
    sup_wait[SUP_MAIN] = (st_q == ST_DN) || (st_q == ST_UP) || (st_q == ST_CM);
    sup_wait[SUP_CORE] = (st_q == ST_CC);
  end

  always_comb begin
    case (st_q)
      ST_D0NI:       state_o = CODE_D0NI;
      ST_D1:         state_o = CODE_D1;
      ST_D2:         state_o = CODE_D2;
      ST_D3H:        state_o = CODE_D3H;
      ST_D3W, ST_UP: state_o = CODE_D3W;
      ST_D3C:        state_o = CODE_D3C;
      default:       state_o = CODE_D0;
    endcase
  end

  assign pme_o  = pme_q;
  assign next_o = nxt_q;
  assign busy_o = busy;
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pwr_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_we,
  input  logic [1:0]      req_next,
  input  logic            req_poff,
  input  logic            cold_req,
  input  logic            host_ps_we,
  input  logic [1:0]      host_ps_val,
  input  logic            pme_en,
  input  logic            init_done,
  input  logic            tmr_wake,
  input  logic            irq_wake,
  input  logic [NSRC-1:0] evt_set,
  input  logic            evt_clr_we,
  input  logic [NSRC-1:0] evt_clr,
  input  logic [NSRC-1:0] wake_mask,
  input  logic            main_pg,
  input  logic            core_pg,
  input  logic [CW-1:0]   tmo_limit,
  output logic            main_en,
  output logic            core_en,
  output logic            pme,
  output logic [2:0]      state_o,
  output logic [1:0]      next_o,
  output logic            busy,
  output logic [NSRC-1:0] evt_o,
  output logic            tmo_err
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            wake_q, host_wr00;
  logic [NSUP-1:0] sup_en, sup_wait, pg_done, pg_in, tmo_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign host_wr00 = host_ps_we & (host_ps_val == 2'b00);
  assign pg_in[SUP_MAIN] = main_pg;
  assign pg_in[SUP_CORE] = core_pg;

  pwr_wake_qual #(.N(NSRC)) u_wake (
    .clk(clk), .rst_n(rst_int_n), .set_i(evt_set), .clr_we_i(evt_clr_we),
    .clr_i(evt_clr), .mask_i(wake_mask), .evt_o(evt_o), .wake_o(wake_q)
  );

  for (genvar g = 0; g < NSUP; g++) begin : g_sup
    pwr_pg_wait #(.CW(CW)) u_pg (
      .clk(clk), .rst_n(rst_int_n), .wait_i(sup_wait[g]), .tgt_i(sup_en[g]),
      .pg_i(pg_in[g]), .limit_i(tmo_limit), .done_o(pg_done[g]), .tmo_o(tmo_vec[g])
    );
  end

  pwr_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .req_we(req_we), .req_next(req_next),
    .req_poff(req_poff), .cold_req(cold_req), .host_wr00(host_wr00),
    .pme_en(pme_en), .init_done(init_done), .tmr_wake(tmr_wake),
    .irq_wake(irq_wake), .wake_q(wake_q), .pg_done(pg_done), .sup_en(sup_en),
    .sup_wait(sup_wait), .pme_o(pme), .next_o(next_o), .state_o(state_o),
    .busy_o(busy)
  );

  assign main_en = sup_en[SUP_MAIN];
  assign core_en = sup_en[SUP_CORE];
  assign tmo_err = |tmo_vec;
endmodule

// File: rtl/pwr_state_seq_chk.sv
module pwr_state_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       main_en,
  input logic       core_en,
  input logic       pme,
  input logic       pme_en,
  input logic       busy,
  input logic [2:0] state_o,
  input logic [1:0] next_o,
  input logic       tmo_err
);
  // R7
  warm_main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && !busy) |-> !main_en);
  // R7
  warm_core_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5) |-> core_en);
  // R9
  cold_both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6) |-> (!main_en && !core_en));
  // R9
  cold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6) |=> (state_o == 3'd6));
  // R5
  pme_agent_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pme && !$past(pme)) |-> $past(pme_en));
  // R8
  uninit_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1) |=> (state_o == 3'd1 || state_o == 3'd0));
  // R10
  busy_next_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(next_o));
  // R11
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> tmo_err);
endmodule

bind pwr_state_seq pwr_state_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .main_en(main_en), .core_en(core_en), .pme(pme),
  .pme_en(pme_en), .busy(busy), .state_o(state_o), .next_o(next_o),
  .tmo_err(tmo_err)
);

// File: tb/pwr_state_seq_bench.sv
`timescale 1ns/1ps
module pwr_state_seq_bench;
  logic clk, rst_n, req_we, req_poff, cold_req, host_ps_we, pme_en, init_done;
  logic tmr_wake, irq_wake, evt_clr_we, main_pg, core_pg;
  logic [1:0] req_next, host_ps_val;
  logic [5:0] evt_set, evt_clr, wake_mask;
  logic [15:0] tmo_limit;
  logic main_en, core_en, pme, busy, tmo_err;
  logic [2:0] state_o;
  logic [1:0] next_o;
  logic [5:0] evt_o;
  int n_chk, n_fail;
  bit done;

  pwr_state_seq u_pwr_state_seq (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic req(logic [1:0] nx, logic poff);
    req_we = 1'b1; req_next = nx; req_poff = poff; tick(); req_we = 1'b0;
  endtask

  task automatic host00();
    host_ps_we = 1'b1; host_ps_val = 2'b00; tick(); host_ps_we = 1'b0;
  endtask

  task automatic evt(logic [5:0] v);
    evt_set = v; tick(); evt_set = '0; tick();
  endtask

  task automatic clr_evt();
    evt_clr_we = 1'b1; evt_clr = '1; tick(); evt_clr_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", state_o, 0);  chk("R1 main_en", main_en, 1);
    chk("R1 core_en", core_en, 1); chk("R1 pme", pme, 0);
    chk("R1 busy", busy, 0);      chk("R1 next", next_o, 0);
    chk("R1 tmo", tmo_err, 0);
  endtask

  task automatic t_decode();
    req(2'b01, 0); chk("R2 D1", state_o, 2); req(2'b00, 0); chk("R2 back D0", state_o, 0);
    req(2'b10, 0); chk("R2 D2", state_o, 3); req(2'b00, 0);
    req(2'b11, 0); chk("R2 D3hot", state_o, 4); chk("R2 main stays on", main_en, 1);
    req(2'b00, 0); chk("R2 exit", state_o, 0); chk("R2 next", next_o, 0);
  endtask

  task automatic t_wake();
    pme_en = 0; wake_mask = '0;
    req(2'b01, 0); evt(6'b000100);
    chk("R3 masked no wake", state_o, 2); chk("R3 event latched", evt_o, 6'b000100);
    wake_mask = 6'b000100; tick();
    chk("R4 host wake", state_o, 0); chk("R4 no pme", pme, 0);
    clr_evt(); chk("R3 w1c", evt_o, 0);
    req(2'b01, 0); tick(2); chk("R3 stale no retrigger", state_o, 2);
    req(2'b00, 0); wake_mask = '0;
  endtask

  task automatic t_agent();
    pme_en = 1; wake_mask = 6'b000001;
    req(2'b10, 0); chk("R5 next before", next_o, 2);
    evt(6'b000001); chk("R5 pme up", pme, 1); chk("R5 state held", state_o, 3);
    tick(3); chk("R5 still held", state_o, 3);
    host00(); chk("R5 host exit", state_o, 0); chk("R5 pme clear", pme, 0);
    chk("R5 next forced", next_o, 0);
    clr_evt(); wake_mask = '0;
  endtask

  task automatic t_tmr_irq();
    pme_en = 1;
    req(2'b11, 0); tmr_wake = 1; tick(); tmr_wake = 0; chk("R6 timer exit", state_o, 0);
    req(2'b01, 0); irq_wake = 1; tick(); irq_wake = 0; chk("R6 irq exit", state_o, 0);
  endtask

  task automatic t_warm();
    pme_en = 0; tmo_limit = 16'd100;
    req(2'b11, 1);
    chk("R7 main off", main_en, 0); chk("R7 busy", busy, 1);
    chk("R7 state during", state_o, 0); chk("R7 core on", core_en, 1);
    req(2'b01, 0); chk("R10 next held", next_o, 3); chk("R10 state held", state_o, 0);
    chk("R10 still busy", busy, 1);
    main_pg = 0; tick();
    chk("R7 warm", state_o, 5); chk("R7 idle", busy, 0); chk("R7 core on warm", core_en, 1);
    chk("R11 no tmo", tmo_err, 0);
    wake_mask = 6'b001000; evt(6'b001000);
    chk("R8 main first", main_en, 1); chk("R8 busy up", busy, 1); chk("R8 reads warm", state_o, 5);
    tick(2); chk("R8 waits pg", busy, 1);
    main_pg = 1; tick(); chk("R8 uninit", state_o, 1);
    tick(2); chk("R8 waits init", state_o, 1);
    init_done = 1; tick(); init_done = 0; chk("R8 active", state_o, 0);
    clr_evt(); wake_mask = '0;
  endtask

  task automatic t_tmo();
    tmo_limit = 16'd3; pme_en = 1;
    req(2'b11, 1); tick(8); chk("R11 timeout", tmo_err, 1);
    main_pg = 0; tick(); chk("R11 warm after late pg", state_o, 5);
    wake_mask = 6'b000001; evt(6'b000001);
    chk("R5 warm pme", pme, 1); chk("R5 warm held", state_o, 5);
    host00(); chk("R5 warm host exit", busy, 1); chk("R5 warm pme clr", pme, 0);
    main_pg = 1; tick(); chk("R8 agent uninit", state_o, 1);
    init_done = 1; tick(); init_done = 0; chk("R8 agent active", state_o, 0);
    chk("R11 sticky", tmo_err, 1);
    clr_evt(); wake_mask = '0;
  endtask

  task automatic t_cold();
    cold_req = 1; tick(); cold_req = 0;
    chk("R9 main off first", main_en, 0); chk("R9 core still on", core_en, 1);
    main_pg = 0; tick(); chk("R9 core off", core_en, 0); chk("R9 state during", state_o, 0);
    core_pg = 0; tick(); chk("R9 cold", state_o, 6);
    req(2'b00, 0); host00(); wake_mask = '1; evt(6'b000001);
    tmr_wake = 1; tick(); tmr_wake = 0; tick();
    chk("R9 cold held", state_o, 6); chk("R9 main off", main_en, 0);
  endtask

  initial begin
    rst_n = 0; req_we = 0; req_next = 0; req_poff = 0; cold_req = 0;
    host_ps_we = 0; host_ps_val = 0; pme_en = 0; init_done = 0;
    tmr_wake = 0; irq_wake = 0; evt_set = 0; evt_clr_we = 0; evt_clr = 0;
    wake_mask = 0; main_pg = 1; core_pg = 1; tmo_limit = 16'd100;
    tick(3); rst_n = 1; tick(3);
    t_reset(); t_decode(); t_wake(); t_agent(); t_tmr_irq();
    t_warm(); t_tmo(); t_cold();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule